// File: doc/BRIEF.md
# Odd-Ratio Clock Divider

This block divides an input clock by an odd whole number N = 2n+1 and gives a square output clock with an exact 50% duty cycle. It does not run one counter over N cycles. It splits each output period into two equal halves of n + ½ input cycles. One half is counted on rising input edges and the other on falling input edges.

Two mirrored stages do the work. The rise stage counts rising edges while the output is low. The fall stage counts falling edges while the output is high. When the active stage's count reaches n, the idle stage waits one more half cycle and then toggles its own flip-flop. The XOR of the two flip-flops is the phase, and the phase is the output. The toggle passes the counting to the other edge polarity and clears the stage that has just finished.

The setting `half_sel` holds n directly, so every ratio the block produces is odd. A 4-bit setting covers divisors 3 to 31. The value 0 is raised to n = 1.

Top module: `odd_clk_div`

## Requirements
- R1: While `rst_n` is low, `clk_div` is 0, even with `clk_in` running.
- R2: In steady state, `clk_div` has a period of exactly 2n+1 `clk_in` periods, where n = `half_sel` for settings 1 to 15 (divide by 3 to 31; setting 12 divides by 25).
- R3: `clk_div` stays high for exactly n + ½ input periods and low for n + ½ input periods. It rises only on a falling `clk_in` edge and falls only on a rising `clk_in` edge.
- R4: After reset is released, the first rising edge of `clk_div` comes on the falling `clk_in` edge that follows the n-th rising `clk_in` edge.
- R5: A `half_sel` of 0 is treated as n = 1, so the block divides by 3.
- R6: The largest setting, `half_sel` = 15, divides by 31 with no counter wrap.
- R7: Pulling `rst_n` low while the output is high forces `clk_div` to 0 at once, without waiting for a `clk_in` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_sel | input | W (4) | n, half-period count; divisor is 2n+1 |
| clk_div | output | 1 | Divided clock, 50% duty |

## Verification
On every terminal count, two things happen on the same input edge in the idle stage: it clears its own counter, and it toggles the phase that hands counting back to it. The bench brings this about at every output transition, including n = 1. With n = 1, the terminal count is reached on the very first counted edge. Each case is judged by the measured high time, low time and period in nanoseconds, compared with (2n+1) × 2 ns and (2n+1) × 4 ns, and by checking that each edge sits on the expected input-edge polarity. If the clear and the toggle were mis-ordered, a half-period would grow or shrink by one edge.

// File: rtl/odd_div_pkg.sv
package odd_div_pkg;
  // which clk_in edge a half-stage counts on
  typedef enum logic {SIDE_RISE = 1'b0, SIDE_FALL = 1'b1} side_e;
  // smallest half-period count the block accepts
  localparam int unsigned ODD_DIV_MIN_N = 1;
endpackage

// File: rtl/odd_div_ratio.sv
module odd_div_ratio #(
  parameter int W = 4
) (
  input  logic [W-1:0] sel,
  output logic [W-1:0] n_lim
);
  localparam logic [W-1:0] MIN_N = W'(odd_div_pkg::ODD_DIV_MIN_N);

  // raise settings below the minimum so a zero never stalls the counter
  always_comb begin
    if (sel < MIN_N) n_lim = MIN_N;
    else             n_lim = sel;
  end
endmodule

// File: rtl/odd_div_half_stage.sv
module odd_div_half_stage
  import odd_div_pkg::*;
#(
  parameter int    W    = 4,
  parameter side_e SIDE = SIDE_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] n_lim,
  input  logic         phase,
  input  logic [W-1:0] peer_cnt,
  output logic [W-1:0] cnt,
  output logic         tog
);
  logic         active;
  logic [W-1:0] cnt_nxt;
  logic         tog_nxt;

  assign active = (phase == logic'(SIDE));

  // active: count own edges up to n and hold there
  // idle: keep counter clear and flip the phase half a cycle after the peer's terminal count
  always_comb begin
    cnt_nxt = cnt;
    tog_nxt = tog;
    if (active) begin
      if (cnt < n_lim) cnt_nxt = cnt + 1'b1;
    end else begin
      cnt_nxt = '0;
      if (peer_cnt >= n_lim) tog_nxt = ~tog;
    end
  end

  generate
    if (SIDE == SIDE_FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
          tog <= 1'b0;
        end else begin
          cnt <= cnt_nxt;
          tog <= tog_nxt;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
          tog <= 1'b0;
        end else begin
          cnt <= cnt_nxt;
          tog <= tog_nxt;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/odd_clk_div.sv
module odd_clk_div
  import odd_div_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic [W-1:0] half_sel,
  output logic         clk_div
);
  localparam int NSIDE = 2;

  logic [W-1:0] n_lim;
  logic [W-1:0] cnt_a [NSIDE];
  logic         tog_a [NSIDE];
  logic         phase;
  logic [W-1:0] cnt_rise;
  logic [W-1:0] cnt_fall;

  odd_div_ratio #(.W(W)) u_ratio (
    .sel   (half_sel),
    .n_lim (n_lim)
  );

  // the XOR of the two half-stage flip-flops picks the counting edge
  assign phase = tog_a[0] ^ tog_a[1];

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    odd_div_half_stage #(.W(W), .SIDE(side_e'(g))) u_stage (
      .clk      (clk_in),
      .rst_n    (rst_n),
      .n_lim    (n_lim),
      .phase    (phase),
      .peer_cnt (cnt_a[NSIDE-1-g]),
      .cnt      (cnt_a[g]),
      .tog      (tog_a[g])
    );
  end

  assign cnt_rise = cnt_a[0];
  assign cnt_fall = cnt_a[1];
  assign clk_div  = phase;
endmodule

// File: rtl/odd_clk_div_chk.sv
module odd_clk_div_chk #(
  parameter int W = 4
) (
  input logic         clk_in,
  input logic         rst_n,
  input logic         clk_div,
  input logic [W-1:0] n_lim,
  input logic [W-1:0] cnt_r,
  input logic [W-1:0] cnt_f
);
  // R1
  reset_low_chk: assert property (@(posedge clk_in) !rst_n |-> !clk_div);

  // R3
  one_counter_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $onehot0({cnt_r != '0, cnt_f != '0}));

  // R5
  min_ratio_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    n_lim != '0);

  // R2
  rise_step_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt_r == '0) || (cnt_r == $past(cnt_r)) || (cnt_r == $past(cnt_r) + 1'b1));

  // R2
  fall_step_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    (cnt_f == '0) || (cnt_f == $past(cnt_f)) || (cnt_f == $past(cnt_f) + 1'b1));
endmodule

bind odd_clk_div odd_clk_div_chk #(.W(W)) u_chk (
  .clk_in  (clk_in),
  .rst_n   (rst_n),
  .clk_div (clk_div),
  .n_lim   (n_lim),
  .cnt_r   (cnt_rise),
  .cnt_f   (cnt_fall)
);

// File: tb/odd_clk_div_bench.sv
`timescale 1ns/1ps
module odd_clk_div_bench;
  localparam int W = 4;
  localparam int NV = 6;
  // setting and the divisor it must give
  localparam int VSEL [NV] = '{1, 2, 12, 7, 0, 15};
  localparam int VDIV [NV] = '{3, 5, 25, 15, 3, 31};

  logic         clk_in = 1'b0;
  logic         rst_n  = 1'b1;
  logic [W-1:0] half_sel = '0;
  logic         clk_div;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  odd_clk_div #(.W(W)) u_odd_clk_div (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .half_sel (half_sel),
    .clk_div  (clk_div)
  );

  always #2 clk_in = ~clk_in;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int sel, input int div);
    longint t_rel, t_r1, t_f1, t_r2, t_r3;
    int n;
    string tag;
    n = (div - 1) / 2;
    tag = (sel == 0) ? "R5" : (sel == 15) ? "R6" : "R2";
    rst_n = 1'b0;
    half_sel = W'(sel);
    repeat (2) @(negedge clk_in);
    #1;
    t_rel = $time;
    rst_n = 1'b1;
    @(posedge clk_div); t_r1 = $time;
    check(t_r1 - t_rel == 4 * n - 1, "R4 first rise delay", t_r1 - t_rel, 4 * n - 1);
    check(t_r1 % 4 == 0, "R3 rise on falling clk_in", t_r1 % 4, 0);
    @(negedge clk_div); t_f1 = $time;
    check(t_f1 - t_r1 == 2 * div, "R3 high time", t_f1 - t_r1, 2 * div);
    check(t_f1 % 4 == 2, "R3 fall on rising clk_in", t_f1 % 4, 2);
    @(posedge clk_div); t_r2 = $time;
    check(t_r2 - t_f1 == 2 * div, "R3 low time", t_r2 - t_f1, 2 * div);
    check(t_r2 - t_r1 == 4 * div, tag, t_r2 - t_r1, 4 * div);
    @(posedge clk_div); t_r3 = $time;
    check(t_r3 - t_r2 == 4 * div, tag, t_r3 - t_r2, 4 * div);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    // R1: output held low while reset is applied and clock runs
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_in); #1;
      check(clk_div == 1'b0, "R1 reset low", clk_div, 0);
    end
    // table walk: R2, R3, R4, R5, R6
    for (int v = 0; v < NV; v++) run_vec(VSEL[v], VDIV[v]);
    // R7: reset mid-high, away from any clk_in edge
    half_sel = 4'd4;
    rst_n = 1'b0;
    repeat (2) @(negedge clk_in);
    #1 rst_n = 1'b1;
    @(posedge clk_div);
    #5;
    check(clk_div == 1'b1, "R7 high before reset", clk_div, 1);
    #0.5 rst_n = 1'b0;
    #0.5;
    check(clk_div == 1'b0, "R7 immediate reset", clk_div, 0);
    repeat (3) @(negedge clk_in);
    #1;
    check(clk_div == 1'b0, "R1 held in reset", clk_div, 0);
    // R4 after reset with divide by 9
    run_vec(4, 9);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule